// File: doc/BRIEF.md
# Fault-Aware Stage Crossbar Allocator

This block reorganises a fabric of four cores with five pipeline stages each (fetch, decode, execute, memory, writeback) after some stage instances have failed. A fault mask marks every broken stage instance. From the mask the block builds as many complete virtual pipelines as the healthy instances allow. Each virtual pipeline chains one healthy instance of every stage type, and those instances may sit in any core.

Between each pair of consecutive stage types there is a crossbar. The block drives the select for every boundary and carries each stage's outgoing register payload, with its valid bit, to the core whose next-stage instance belongs to the same virtual pipeline. Each crossbar adds a set number of register stages, set by a parameter: one for a planar build and two for a stacked build. Data and valid pass through the same registers, so they stay aligned.

A new mask takes effect only when the reconfigure strobe is high. The new configuration appears on the cycle after the strobe, together with a one-cycle done pulse.

Top module: `stage_fabric_alloc`

## Requirements
- R1: Out of reset, every instance counts as faulty until the first strobe. The pipeline count is 0, all pipeline valid bits are 0, all selects are 0, done is 0, and every destination payload and valid is 0.
- R2: The pipeline count equals the smallest, over the five stage types, of the number of healthy instances of that type. Mask bit 4*s+c marks stage s (fetch=0, decode=1, execute=2, memory=3, writeback=4) of core c as faulty when set.
- R3: Pipeline k uses, for each stage type, the healthy instance with the k-th lowest core index (counting from 0). Its select for stage s is the binary core index at bits [(k*5+s)*2 +: 2] of `pipe_sel_o`.
- R4: Pipeline valid bit k is 1 exactly when k is below the pipeline count. All select fields of pipelines that are not valid are 0.
- R5: A faulty instance is never selected by a valid pipeline and never receives or supplies routed payload.
- R6: When the strobe is low, changes on the fault mask have no effect: selects, valid bits and count hold, and done stays 0.
- R7: A mask present while the strobe is high at a clock edge is reflected on the outputs in the cycle after that edge. Done is 1 in that cycle and 0 in any cycle that follows a cycle with the strobe low.
- R8: At boundary b (between stage b and stage b+1), the destination slot b*4+d receives the payload and valid from source slot b*4+c, where c is the stage-b core and d is the stage-(b+1) core of the same valid pipeline. The payload arrives exactly XBAR_LAT cycles after it was presented, with its valid bit in the same cycle.
- R9: A destination slot that no valid pipeline uses outputs payload 0 and valid 0.
- R10: With only fetch of core 0 and execute of core 1 faulty, three pipelines are formed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reconf_i | input | 1 | Reconfigure strobe; the mask is sampled while high |
| fault_mask_i | input | 20 | One bit per stage instance, bit 4*s+c, 1 = faulty |
| pipe_sel_o | output | 40 | Core index per pipeline and stage, field (k*5+s)*2 |
| pipe_vld_o | output | 4 | One valid bit per virtual pipeline |
| pipe_cnt_o | output | 3 | Number of valid pipelines |
| reconf_done_o | output | 1 | One-cycle pulse when a new configuration takes effect |
| src_data_i | input | 512 | Stage-b output payload of core c, slot b*4+c, 32 bits each |
| src_vld_i | input | 16 | Valid for each source slot |
| dst_data_o | output | 512 | Stage-(b+1) input payload for core d, slot b*4+d |
| dst_vld_o | output | 16 | Valid for each destination slot |

## Verification
The bench goes after these corner cases:
- An execute column with one fault beside a fetch column with a different fault. An allocator that kept core alignment, or took the minimum wrongly, would report four pipelines or select a dead instance.
- A stage type that is entirely faulty, and a fully faulty mask. These must give zero pipelines with all selects cleared. A design that leaves stale fields on unused pipelines fails here.
- Mask changes with the strobe low, which must leave every output alone.
- Payload routed across cores with a two-register crossbar. Here a valid bit one cycle out of step with its data, or an idle destination that leaks a neighbour's payload, shows up as a slot mismatch.

// File: rtl/xbar_fabric_pkg.sv
// Shared definitions for the stage crossbar fabric.
// Assumes stage types are numbered in pipeline order, fetch first.
package xbar_fabric_pkg;
    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WBACK  = 3'd4
    } stage_e;

    // Index of instance (stage s, core c) inside the fault mask.
    function automatic int inst_idx(input int s, input int c, input int n_cores);
        return s * n_cores + c;
    endfunction

    // Bit offset of the select field of pipeline k, stage s.
    function automatic int sel_off(input int k, input int s, input int n_stages, input int sel_w);
        return (k * n_stages + s) * sel_w;
    endfunction
endpackage

// File: rtl/stage_alloc.sv
// Allocation engine: keeps the applied fault mask and derives, for every
// virtual pipeline, which core supplies each stage type. Pipeline k takes
// the k-th lowest healthy core of every type; the pipeline count is the
// minimum healthy count over all types. Assumes N_CORES >= 2.
module stage_alloc
    import xbar_fabric_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_STAGES = 5,
    localparam int SEL_W   = $clog2(N_CORES),
    localparam int CNT_W   = $clog2(N_CORES + 1),
    localparam int MASK_W  = N_CORES * N_STAGES,
    localparam int PSEL_W  = N_CORES * N_STAGES * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reconf_i,
    input  logic [MASK_W-1:0] fault_mask_i,
    output logic [PSEL_W-1:0] pipe_sel_o,
    output logic [N_CORES-1:0] pipe_vld_o,
    output logic [CNT_W-1:0]  pipe_cnt_o,
    output logic              done_o
);
    logic [MASK_W-1:0] mask_q;
    logic [CNT_W-1:0]  hcnt [N_STAGES];
    logic [SEL_W-1:0]  raw  [N_STAGES][N_CORES];
    logic [CNT_W-1:0]  cnt;

    // Capture the mask on a strobe; out of reset everything counts as faulty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            done_o <= 1'b0;
        end else begin
            done_o <= reconf_i;
            if (reconf_i) mask_q <= fault_mask_i;
        end
    end

    // Rank healthy instances per stage type in ascending core order.
    always_comb begin
        for (int s = 0; s < N_STAGES; s++) begin
            hcnt[s] = '0;
            for (int k = 0; k < N_CORES; k++) raw[s][k] = '0;
            for (int c = 0; c < N_CORES; c++) begin
                if (!mask_q[inst_idx(s, c, N_CORES)]) begin
                    for (int k = 0; k < N_CORES; k++)
                        if (hcnt[s] == CNT_W'(k)) raw[s][k] = SEL_W'(c);
                    hcnt[s] = hcnt[s] + CNT_W'(1);
                end
            end
        end
    end

    // Pipeline count is the scarcest stage type.
    always_comb begin
        cnt = CNT_W'(N_CORES);
        for (int s = 0; s < N_STAGES; s++)
            if (hcnt[s] < cnt) cnt = hcnt[s];
    end

    // Drive selects and valids, clearing pipelines that cannot be built.
    always_comb begin
        for (int k = 0; k < N_CORES; k++) begin
            pipe_vld_o[k] = (CNT_W'(k) < cnt);
            for (int s = 0; s < N_STAGES; s++)
                pipe_sel_o[sel_off(k, s, N_STAGES, SEL_W) +: SEL_W] =
                    (CNT_W'(k) < cnt) ? raw[s][k] : '0;
        end
    end

    assign pipe_cnt_o = cnt;

    // R4
    vld_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pipe_vld_o) == int'(pipe_cnt_o));

    // R6
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reconf_i) |-> ($stable(pipe_sel_o) && $stable(pipe_cnt_o)));

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(reconf_i));

    genvar gk, gs;
    generate
        for (gk = 1; gk < N_CORES; gk++) begin : g_thermo
            // R4
            vld_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pipe_vld_o[gk] |-> pipe_vld_o[gk-1]);
        end
        for (gk = 0; gk < N_CORES; gk++) begin : g_pk
            for (gs = 0; gs < N_STAGES; gs++) begin : g_ps
                // R5
                no_dead_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    pipe_vld_o[gk] |-> !mask_q[gs * N_CORES +
                        int'(pipe_sel_o[sel_off(gk, gs, N_STAGES, SEL_W) +: SEL_W])]);
            end
        end
    endgenerate
endmodule

// File: rtl/xbar_delay.sv
// Register chain of LAT stages carrying a payload and its valid bit
// together, so that valid never drifts from its data. Assumes LAT >= 1.
module xbar_delay #(
    parameter int W   = 32,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_vld,
    output logic [W-1:0] out_data,
    output logic         out_vld
);
    logic [W:0] stg_q [LAT];

    // Shift valid and data through the latency stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= {in_vld, in_data};
            for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign out_vld  = stg_q[LAT-1][W];
    assign out_data = stg_q[LAT-1][W-1:0];

    generate
        if (LAT == 1) begin : g_l1
            // R8
            vld_lat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |=> out_vld);
        end else if (LAT == 2) begin : g_l2
            // R8
            vld_lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && $past(rst_n)) |=> ##1 out_vld);
        end
    endgenerate
endmodule

// File: rtl/xbar_route.sv
// One inter-stage crossbar. For each destination core it finds the valid
// pipeline whose next-stage instance lives there and selects the payload
// of that pipeline's current-stage core, then delays it by LAT registers.
// Destinations that no pipeline uses get zero payload and zero valid.
module xbar_route
    import xbar_fabric_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_STAGES = 5,
    parameter int DATA_W   = 32,
    parameter int LAT      = 1,
    parameter int BND      = 0,
    localparam int SEL_W   = $clog2(N_CORES),
    localparam int CNT_W   = $clog2(N_CORES + 1),
    localparam int PSEL_W  = N_CORES * N_STAGES * SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PSEL_W-1:0]           pipe_sel,
    input  logic [N_CORES-1:0]          pipe_vld,
    input  logic [CNT_W-1:0]            pipe_cnt,
    input  logic [N_CORES*DATA_W-1:0]   src_data,
    input  logic [N_CORES-1:0]          src_vld,
    output logic [N_CORES*DATA_W-1:0]   dst_data,
    output logic [N_CORES-1:0]          dst_vld
);
    logic [N_CORES-1:0] hit;
    logic [N_CORES-1:0] claim  [N_CORES];
    logic [SEL_W-1:0]   srcsel [N_CORES];
    logic [DATA_W-1:0]  mux_d  [N_CORES];
    logic [N_CORES-1:0] mux_v;

    // Map each destination core to its source core through the pipelines.
    always_comb begin
        for (int d = 0; d < N_CORES; d++) begin
            hit[d]    = 1'b0;
            srcsel[d] = '0;
            for (int k = 0; k < N_CORES; k++) begin
                claim[d][k] = pipe_vld[k] &&
                    (pipe_sel[sel_off(k, BND + 1, N_STAGES, SEL_W) +: SEL_W] == SEL_W'(d));
                if (claim[d][k]) begin
                    hit[d]    = 1'b1;
                    srcsel[d] = pipe_sel[sel_off(k, BND, N_STAGES, SEL_W) +: SEL_W];
                end
            end
        end
    end

    // Select payload per destination, gated off when unused.
    always_comb begin
        for (int d = 0; d < N_CORES; d++) begin
            mux_d[d] = hit[d] ? src_data[int'(srcsel[d]) * DATA_W +: DATA_W] : '0;
            mux_v[d] = hit[d] && src_vld[int'(srcsel[d])];
        end
    end

    genvar gd;
    generate
        for (gd = 0; gd < N_CORES; gd++) begin : g_dst
            xbar_delay #(.W(DATA_W), .LAT(LAT)) u_dly (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_data  (mux_d[gd]),
                .in_vld   (mux_v[gd]),
                .out_data (dst_data[gd*DATA_W +: DATA_W]),
                .out_vld  (dst_vld[gd])
            );
            // R5
            one_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(claim[gd]));
        end
    endgenerate

    // R9
    used_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) == int'(pipe_cnt));
endmodule

// File: rtl/stage_fabric_alloc.sv
// Top of the fault-aware stage fabric: an allocation engine feeding one
// crossbar per stage boundary. Source slot b*N_CORES+c is the stage-b
// output of core c; destination slot b*N_CORES+d is the stage-(b+1) input
// of core d. Assumes N_STAGES >= 2 and XBAR_LAT >= 1.
module stage_fabric_alloc #(
    parameter int N_CORES  = 4,
    parameter int N_STAGES = 5,
    parameter int DATA_W   = 32,
    parameter int XBAR_LAT = 1,
    localparam int SEL_W   = $clog2(N_CORES),
    localparam int CNT_W   = $clog2(N_CORES + 1),
    localparam int MASK_W  = N_CORES * N_STAGES,
    localparam int PSEL_W  = N_CORES * N_STAGES * SEL_W,
    localparam int N_BND   = N_STAGES - 1,
    localparam int SLOTS   = N_BND * N_CORES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reconf_i,
    input  logic [MASK_W-1:0]         fault_mask_i,
    output logic [PSEL_W-1:0]         pipe_sel_o,
    output logic [N_CORES-1:0]        pipe_vld_o,
    output logic [CNT_W-1:0]          pipe_cnt_o,
    output logic                      reconf_done_o,
    input  logic [SLOTS*DATA_W-1:0]   src_data_i,
    input  logic [SLOTS-1:0]          src_vld_i,
    output logic [SLOTS*DATA_W-1:0]   dst_data_o,
    output logic [SLOTS-1:0]          dst_vld_o
);
    stage_alloc #(.N_CORES(N_CORES), .N_STAGES(N_STAGES)) u_alloc (
        .clk          (clk),
        .rst_n        (rst_n),
        .reconf_i     (reconf_i),
        .fault_mask_i (fault_mask_i),
        .pipe_sel_o   (pipe_sel_o),
        .pipe_vld_o   (pipe_vld_o),
        .pipe_cnt_o   (pipe_cnt_o),
        .done_o       (reconf_done_o)
    );

    genvar gb;
    generate
        for (gb = 0; gb < N_BND; gb++) begin : g_bnd
            xbar_route #(
                .N_CORES (N_CORES),
                .N_STAGES(N_STAGES),
                .DATA_W  (DATA_W),
                .LAT     (XBAR_LAT),
                .BND     (gb)
            ) u_xbar (
                .clk      (clk),
                .rst_n    (rst_n),
                .pipe_sel (pipe_sel_o),
                .pipe_vld (pipe_vld_o),
                .pipe_cnt (pipe_cnt_o),
                .src_data (src_data_i[gb*N_CORES*DATA_W +: N_CORES*DATA_W]),
                .src_vld  (src_vld_i[gb*N_CORES +: N_CORES]),
                .dst_data (dst_data_o[gb*N_CORES*DATA_W +: N_CORES*DATA_W]),
                .dst_vld  (dst_vld_o[gb*N_CORES +: N_CORES])
            );
        end
    endgenerate
endmodule

// File: tb/stage_fabric_alloc_test.sv
// Bench: directed fault masks plus seeded random masks and payload traffic,
// compared against a model of the allocation rules.
module stage_fabric_alloc_test;
    localparam int NC = 4, NS = 5, DW = 32, LAT = 2;
    localparam int SW = 2, CW = 3, NB = NS - 1, MW = NC * NS;
    localparam int PSW = NC * NS * SW, SL = NB * NC;

    logic clk = 1'b0, rst_n = 1'b0, reconf = 1'b0;
    logic [MW-1:0] mask = '0;
    logic [PSW-1:0] sel;
    logic [NC-1:0] vld;
    logic [CW-1:0] cnt;
    logic done;
    logic [SL*DW-1:0] sdata = '0, ddata;
    logic [SL-1:0] svld = '0, dvld;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int m_sel [NC][NS];
    int m_cnt;
    logic [SL*DW-1:0] hd [LAT];
    logic [SL-1:0] hv [LAT];

    stage_fabric_alloc #(.N_CORES(NC), .N_STAGES(NS), .DATA_W(DW), .XBAR_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .reconf_i(reconf), .fault_mask_i(mask),
        .pipe_sel_o(sel), .pipe_vld_o(vld), .pipe_cnt_o(cnt), .reconf_done_o(done),
        .src_data_i(sdata), .src_vld_i(svld), .dst_data_o(ddata), .dst_vld_o(dvld));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the allocation rules (R2, R3, R4).
    task automatic model(input logic [MW-1:0] m);
        int h [NS];
        m_cnt = NC;
        for (int s = 0; s < NS; s++) begin
            h[s] = 0;
            for (int k = 0; k < NC; k++) m_sel[k][s] = 0;
            for (int c = 0; c < NC; c++)
                if (!m[s*NC+c]) begin m_sel[h[s]][s] = c; h[s]++; end
            if (h[s] < m_cnt) m_cnt = h[s];
        end
        for (int k = 0; k < NC; k++)
            if (k >= m_cnt) for (int s = 0; s < NS; s++) m_sel[k][s] = 0;
    endtask

    function automatic logic [PSW-1:0] exp_sel();
        logic [PSW-1:0] v = '0;
        for (int k = 0; k < NC; k++)
            for (int s = 0; s < NS; s++) v[(k*NS+s)*SW +: SW] = SW'(m_sel[k][s]);
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_vld();
        logic [NC-1:0] v = '0;
        for (int k = 0; k < NC; k++) v[k] = (k < m_cnt);
        return v;
    endfunction

    // Strobe a mask and check the configuration and the done pulse (R7).
    task automatic apply(input logic [MW-1:0] m, input string req);
        @(negedge clk); mask = m; reconf = 1'b1;
        @(negedge clk); reconf = 1'b0;
        model(m);
        chk("R7 done", 64'(done), 64'd1);
        chk({req, " cnt"}, 64'(cnt), 64'(m_cnt));
        chk("R4 vld", 64'(vld), 64'(exp_vld()));
        chk("R3 sel", 64'(sel), 64'(exp_sel()));
        @(negedge clk);
        chk("R7 done low", 64'(done), 64'd0);
    endtask

    // Random payload traffic, compared LAT cycles later (R8, R9, R5).
    task automatic traffic(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                for (int b = 0; b < NB; b++)
                    for (int d = 0; d < NC; d++) begin
                        logic [DW:0] e = '0;
                        bit used = 0;
                        for (int k = 0; k < m_cnt; k++)
                            if (m_sel[k][b+1] == d) begin
                                used = 1;
                                e = {hv[LAT-1][b*NC + m_sel[k][b]],
                                     hd[LAT-1][(b*NC + m_sel[k][b])*DW +: DW]};
                            end
                        chk(used ? "R8 route" : "R9 idle",
                            64'({dvld[b*NC+d], ddata[(b*NC+d)*DW +: DW]}), 64'(e));
                    end
            end
            for (int j = LAT-1; j > 0; j--) begin hd[j] = hd[j-1]; hv[j] = hv[j-1]; end
            for (int w = 0; w < SL; w++) sdata[w*DW +: DW] = $urandom;
            svld = SL'($urandom);
            hd[0] = sdata; hv[0] = svld;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", 64'(cnt), 64'd0);
        chk("R1 vld", 64'(vld), 64'd0);
        chk("R1 sel", 64'(sel), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        m_cnt = 0;
        for (int k = 0; k < NC; k++) for (int s = 0; s < NS; s++) m_sel[k][s] = 0;
        traffic(6);
        chk("R1 dst", 64'({dvld, 16'h0}), 64'd0);

        apply('0, "R2 all healthy");
        traffic(8);
        // R10: fetch core0 and execute core1 faulty
        apply(MW'((1 << 0) | (1 << 9)), "R10");
        chk("R10 three", 64'(cnt), 64'd3);
        traffic(10);
        // R2: ten scattered faults leave two per type
        apply(MW'((1<<0)|(1<<5)|(1<<8)|(1<<13)|(1<<16)|(1<<2)|(1<<7)|(1<<10)|(1<<15)|(1<<18)), "R2 ten");
        traffic(10);
        // R4: memory column dead
        apply(MW'(20'hF << 12), "R4 dead type");
        traffic(6);
        apply('1, "R4 all dead");
        apply(MW'((1<<1)|(1<<6)|(1<<11)|(1<<12)|(1<<19)), "R2 one per type");
        traffic(8);

        // R6: mask changes without strobe are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); mask = MW'($urandom);
            @(negedge clk);
            chk("R6 sel", 64'(sel), 64'(exp_sel()));
            chk("R6 cnt", 64'(cnt), 64'(m_cnt));
            chk("R6 done", 64'(done), 64'd0);
        end
        traffic(6);

        for (int r = 0; r < 40; r++) begin
            apply(MW'($urandom & $urandom & $urandom), "R2 random");
            traffic(8);
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule